// File: doc/BRIEF.md
# Clock-Synchronous Byte Serial Port

This block moves one byte at a time over a three-wire synchronous link. A single shared shift register sends its contents on a serial data output and, on the same clock pulses, collects a byte from a serial data input. When software writes a byte into the data register, a transfer starts. After eight clock pulses the register holds the received byte, and a one-cycle interrupt pulse marks the end of the transfer.

The transfer clock can come from either of two places. In internal mode the block generates it and drives the clock pin. The base clock passes through a prescaler that divides it by 1, 8 or 32. A programmable divider then sets the length of each clock half to n+1 prescaled ticks. In external mode the clock pin is an input. The block synchronises it and shifts on its edges. A polarity bit picks the clock idle level and which edge drives data. A bit-order bit picks whether bit 0 or bit 7 goes out first. After an internal-clock transfer, the data output keeps its last bit for half a clock period and then releases the line. In external mode the output drives a programmable level whenever no transfer is running.

Top module: `csio_port`

## Requirements
- R1: After reset, all registers read zero, irq is 0 and sclk_oe is 0. Because control 0 selects external mode with idle level 0, sdo_oe is 1 and sdo is 0. Register addresses are: 0 control, 1 divider, 2 data, 3 status.
- R2: Control bits [1:0] pick the prescaler: 00 gives 1, 01 gives 8, and 10 or 11 give 32. Control bit 2 set to 1 selects internal mode. In internal mode, successive edges of sclk_out are spaced (n+1)*prescale base clocks apart, where n is the divider register value.
- R3: Every transfer moves exactly 8 bits out and 8 bits in on the same pulses. After irq, reading address 2 returns the received byte.
- R4: Control bit 3 picks the bit order. At 0 the byte goes out starting with bit 0, and received bits fill positions 0 upward. At 1 the byte goes out starting with bit 7, and received bits fill positions 7 downward.
- R5: Control bit 4 is the polarity. At 0 the clock idles high, data changes on the falling edge and is sampled on the rising edge. At 1 the clock idles low and both edges swap roles.
- R6: irq is a single-cycle pulse. It is raised in the same cycle as the edge that samples the eighth bit, and at no other time.
- R7: In internal mode, sdo_oe stays 1 and sdo keeps the last bit for (n+1)*prescale cycles from the irq cycle onward. After that sdo_oe goes to 0, and it stays 0 while idle.
- R8: A data write made during that hold window drops sdo_oe to 0 in the next cycle and starts a new transfer.
- R9: In external mode sclk_oe is 0 and shifting follows the edges on sclk_in. While no bits are being driven, sdo_oe is 1 and sdo equals control bit 5.
- R10: Status bit 0 shows busy, from the start write until irq. A data write while busy is ignored, so the transfer goes on with the original byte, and it sets status bit 1. Any write to address 3 clears status bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| sclk_in | input | 1 | Transfer clock input (external mode) |
| sclk_out | output | 1 | Transfer clock output |
| sclk_oe | output | 1 | Clock pin output enable |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Data output enable, 0 means high-impedance |
| irq | output | 1 | Transfer-complete pulse |

## Verification
On every cycle the assertions check the following: irq stays one cycle wide, busy ends only together with irq, a rejected write keeps the port busy and sets the error flag, the clock rests at its idle level, the data output is released when an internal-mode port is idle, and a write during the hold window releases it at once. The bench has to show the rest through its scenarios. That covers the edge spacing for each prescaler and divider value, the bit order on the wire and in the received byte, the exact length of the hold window, and shifting driven by an external clock against the programmed idle level.

// File: rtl/csio_pkg.sv
package csio_pkg;
  localparam int SIO_DATA_W = 8;
  localparam int SIO_DIV_W  = 8;
  localparam int PRE_MID    = 8;
  localparam int PRE_MAX    = 32;
  localparam int CNT_W      = SIO_DIV_W + $clog2(PRE_MAX) + 1;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIV  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} xfer_st_t;

  typedef struct packed {
    logic [1:0] spare;
    logic       idle_lvl;
    logic       pol;
    logic       msb_first;
    logic       int_clk;
    logic [1:0] pre_sel;
  } ctrl_t;

  // base clocks per half transfer-clock period
  function automatic logic [CNT_W-1:0] half_period(input logic [SIO_DIV_W-1:0] n,
                                                   input logic [1:0] sel);
    logic [CNT_W-1:0] m;
    m = CNT_W'(n) + CNT_W'(1);
    case (sel)
      2'b00:   half_period = m;
      2'b01:   half_period = m * CNT_W'(PRE_MID);
      default: half_period = m * CNT_W'(PRE_MAX);
    endcase
  endfunction
endpackage

// File: rtl/csio_baud.sv
module csio_baud
  import csio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 restart,
  input  logic [SIO_DIV_W-1:0] div_n,
  input  logic [1:0]           pre_sel,
  output logic                 tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hp;

  assign hp   = half_period(div_n, pre_sel);
  assign tick = run && !restart && (cnt == hp - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart || !run) cnt <= '0;
    else if (tick)            cnt <= '0;
    else                      cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/csio_sync.sv
module csio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic lead,
  output logic trail
);
  logic [STAGES:0] sh;
  logic cur, prev, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign cur   = sh[STAGES-1];
  assign prev  = sh[STAGES];
  assign rise  = cur & ~prev;
  assign fall  = ~cur & prev;
  assign lead  = pol ? rise : fall;
  assign trail = pol ? fall : rise;
endmodule

// File: rtl/csio_shifter.sv
module csio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              drive,
  input  logic              sample,
  input  logic              msb_first,
  input  logic              sdi,
  output logic [DATA_W-1:0] shreg,
  output logic              out_bit,
  output logic              last_sample
);
  localparam int BC_W = $clog2(DATA_W);
  logic [BC_W-1:0] bcnt;

  assign last_sample = sample && (bcnt == BC_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      bcnt  <= '0;
    end else if (load) begin
      shreg <= load_val;
      bcnt  <= '0;
    end else if (sample) begin
      shreg <= msb_first ? {shreg[DATA_W-2:0], sdi} : {sdi, shreg[DATA_W-1:1]};
      bcnt  <= bcnt + BC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_bit <= 1'b0;
    else if (drive) out_bit <= msb_first ? shreg[DATA_W-1] : shreg[0];
  end
endmodule

// File: rtl/csio_port.sv
module csio_port
  import csio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       sclk_in,
  output logic       sclk_out,
  output logic       sclk_oe,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  output logic       irq
);
  ctrl_t                 ctrl;
  logic [SIO_DIV_W-1:0]  div_n;
  xfer_st_t              st;
  logic                  phase, sclk_act, oe_q, err_q;
  logic                  tick, ext_lead, ext_trail;
  logic                  step_lead, step_trail, done;
  logic [SIO_DATA_W-1:0] shreg;
  logic                  out_bit, last_sample;

  // named events for the checker
  logic int_clk, pol, busy, hold_st, data_wr, start, reject;
  assign int_clk = ctrl.int_clk;
  assign pol     = ctrl.pol;
  assign busy    = (st == ST_RUN);
  assign hold_st = (st == ST_HOLD);
  assign data_wr = wr_en && (wr_addr == A_DATA);
  assign start   = data_wr && !busy;
  assign reject  = data_wr && busy;

  csio_baud u_baud (
    .clk(clk), .rst_n(rst_n), .run((st != ST_IDLE) && int_clk), .restart(start),
    .div_n(div_n), .pre_sel(ctrl.pre_sel), .tick(tick)
  );

  csio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sclk_in), .pol(pol),
    .lead(ext_lead), .trail(ext_trail)
  );

  assign step_lead  = busy && (int_clk ? (tick && !phase) : ext_lead);
  assign step_trail = busy && (int_clk ? (tick && phase) : ext_trail);
  assign done       = last_sample;

  csio_shifter #(.DATA_W(SIO_DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(wr_data),
    .drive(step_lead), .sample(step_trail), .msb_first(ctrl.msb_first),
    .sdi(sdi), .shreg(shreg), .out_bit(out_bit), .last_sample(last_sample)
  );

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      div_n <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) ctrl  <= ctrl_t'(wr_data);
      if (wr_en && wr_addr == A_DIV)  div_n <= wr_data;
      if (reject)                          err_q <= 1'b1;
      else if (wr_en && wr_addr == A_STAT) err_q <= 1'b0;
    end
  end

  // transfer sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      phase    <= 1'b0;
      sclk_act <= 1'b0;
      oe_q     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= done;
      if (start) begin
        st       <= ST_RUN;
        phase    <= 1'b0;
        sclk_act <= 1'b0;
        oe_q     <= 1'b0;
      end else begin
        case (st)
          ST_RUN: begin
            if (step_lead) begin
              phase    <= 1'b1;
              sclk_act <= 1'b1;
              oe_q     <= 1'b1;
            end
            if (step_trail) begin
              phase    <= 1'b0;
              sclk_act <= 1'b0;
              if (done) begin
                st <= int_clk ? ST_HOLD : ST_IDLE;
                if (!int_clk) oe_q <= 1'b0;
              end
            end
          end
          ST_HOLD: begin
            if (tick || !int_clk) begin
              oe_q <= 1'b0;
              st   <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sclk_oe  = int_clk;
  assign sclk_out = (sclk_act & int_clk) ^ ~pol;
  assign sdo_oe   = int_clk ? oe_q : 1'b1;
  assign sdo      = (int_clk || oe_q) ? out_bit : ctrl.idle_lvl;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = ctrl;
      A_DIV:   rd_data = div_n;
      A_DATA:  rd_data = shreg;
      default: rd_data = {6'b0, err_q, busy};
    endcase
  end
endmodule

// File: rtl/csio_port_chk.sv
module csio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       busy,
  input logic       err_q,
  input logic       hold_st,
  input logic       int_clk,
  input logic       pol,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       sclk_out,
  input logic       sclk_oe,
  input logic       sdo_oe
);
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r10_busy_ends_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  a_r10_reject_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && busy) |=> (busy && err_q));

  a_r5_idle_clock_level: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && !busy) |-> (sclk_out == !pol));

  a_r7_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clk && !busy && !hold_st) |-> !sdo_oe);

  a_r8_hold_write_release: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clk && hold_st && wr_en && wr_addr == 2'd2) |=> (busy && !sdo_oe));
endmodule

bind csio_port csio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .busy(busy), .err_q(err_q),
  .hold_st(hold_st), .int_clk(int_clk), .pol(pol), .wr_en(wr_en),
  .wr_addr(wr_addr), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdo_oe(sdo_oe)
);

// File: tb/csio_port_test.sv
`timescale 1ns/1ps
module csio_port_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wr_en, sclk_in, sdi;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic sclk_out, sclk_oe, sdo, sdo_oe, irq;
  int checks = 0, fails = 0;

  csio_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq)
  );

  function automatic int hp_of(int n, int sel);
    int pre;
    pre = (sel == 0) ? 1 : (sel == 1) ? 8 : 32;
    return (n + 1) * pre;
  endfunction

  function automatic logic [7:0] ctrl_of(bit ic, int sel, bit msb, bit pol, bit idle);
    return {2'b00, idle, pol, msb, ic, 2'(sel)};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic wait_sclk(logic lvl, output int cyc);
    cyc = 0;
    while (sclk_out !== lvl && cyc < 40000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // hold_mode 0: measure hold window; 1: write nxt during hold window
  task automatic xfer_int(logic [7:0] tx, logic [7:0] rxv, int n, int sel, bit msb, bit pol,
                          bit start_it, bit poke, int hold_mode, logic [7:0] nxt);
    int hp, cyc, cnt;
    bit stable, lastb, eb;
    logic [7:0] v;
    hp = hp_of(n, sel);
    if (start_it) begin
      wr(2'd0, ctrl_of(1'b1, sel, msb, pol, 1'b0));
      wr(2'd1, 8'(n));
      chk(sclk_out === !pol && sclk_oe === 1'b1, "R5", "idle clock", sclk_out, !pol);
      chk(sdo_oe === 1'b0, "R7", "idle oe", sdo_oe, 0);
      wr(2'd2, tx);
    end
    for (int i = 0; i < 8; i++) begin
      wait_sclk(pol, cyc);
      if (i > 0) chk(cyc == hp, "R2", "lead spacing", cyc, hp);
      eb = msb ? tx[7-i] : tx[i];
      chk(sdo === eb && sdo_oe === 1'b1, "R4", "tx bit", sdo, eb);
      sdi = msb ? rxv[7-i] : rxv[i];
      if (poke && i == 2) begin
        wr(2'd2, ~tx);
        rd(2'd3, v);
        chk(v[1:0] == 2'b11, "R10", "busy+err after rejected write", v, 3);
      end
      wait_sclk(!pol, cyc);
      if (!(poke && i == 2)) chk(cyc == hp, "R2", "trail spacing", cyc, hp);
      chk(irq === (i == 7), "R6", "irq timing", irq, (i == 7));
    end
    rd(2'd3, v);
    chk(v[0] == 1'b0, "R10", "busy cleared", v[0], 0);
    rd(2'd2, v);
    chk(v == rxv, "R3", "received byte", v, rxv);
    lastb = msb ? tx[0] : tx[7];
    if (hold_mode == 0) begin
      cnt = 0; stable = 1;
      while (sdo_oe === 1'b1 && cnt < 20000) begin
        if (sdo !== lastb) stable = 0;
        cnt++;
        @(negedge clk);
      end
      chk(cnt == hp, "R7", "hold length", cnt, hp);
      chk(stable, "R7", "hold level", stable, 1);
    end else begin
      wr(2'd2, nxt);
      chk(sdo_oe === 1'b0, "R8", "release on hold write", sdo_oe, 0);
      rd(2'd3, v);
      chk(v[0] == 1'b1, "R8", "new transfer busy", v[0], 1);
    end
  endtask

  task automatic xfer_ext(logic [7:0] tx, logic [7:0] rxv, bit msb, bit pol, bit idle);
    int nirq;
    bit eb;
    logic [7:0] v;
    sclk_in = !pol;
    wr(2'd0, ctrl_of(1'b0, 0, msb, pol, idle));
    repeat (4) @(negedge clk);
    chk(sclk_oe === 1'b0 && sdo_oe === 1'b1 && sdo === idle, "R9", "ext idle pins",
        {sclk_oe, sdo_oe, sdo}, {2'b01, idle});
    wr(2'd2, tx);
    chk(sdo === idle, "R9", "idle before first edge", sdo, idle);
    for (int i = 0; i < 8; i++) begin
      sclk_in = pol;
      repeat (8) @(negedge clk);
      eb = msb ? tx[7-i] : tx[i];
      chk(sdo === eb, "R9", "ext tx bit", sdo, eb);
      sdi = msb ? rxv[7-i] : rxv[i];
      sclk_in = !pol;
      nirq = 0;
      repeat (8) begin
        @(negedge clk);
        if (irq) nirq++;
      end
      chk(nirq == ((i == 7) ? 1 : 0), "R6", "ext irq count", nirq, (i == 7));
    end
    rd(2'd2, v);
    chk(v == rxv, "R9", "ext received byte", v, rxv);
    chk(sdo === idle && sdo_oe === 1'b1, "R9", "idle level after", sdo, idle);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    sclk_in = 1'b1; sdi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq === 1'b0 && sclk_oe === 1'b0, "R1", "irq/sclk_oe", {irq, sclk_oe}, 0);
    chk(sdo_oe === 1'b1 && sdo === 1'b0, "R1", "sdo pins", {sdo_oe, sdo}, 2);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 8'h00, "R1", "register reset", v, 0);
    end

    // directed: fastest clock, both orders and polarities
    xfer_int(8'hA5, 8'h3C, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 8'h00);
    xfer_int(8'h1E, 8'hC7, 0, 0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 8'h00);
    // prescaler variants
    xfer_int(8'h6B, 8'h59, 2, 1, 1'b0, 1'b1, 1'b1, 1'b0, 0, 8'h00);
    xfer_int(8'hF0, 8'h0F, 1, 2, 1'b1, 1'b0, 1'b1, 1'b0, 0, 8'h00);
    xfer_int(8'h81, 8'h7E, 0, 3, 1'b0, 1'b0, 1'b1, 1'b0, 0, 8'h00);
    // rejected write while busy
    xfer_int(8'h81, 8'hE7, 3, 0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 8'h00);
    wr(2'd3, 8'h00);
    rd(2'd3, v);
    chk(v[1] == 1'b0, "R10", "error cleared", v[1], 0);
    // write during the hold window
    xfer_int(8'h5A, 8'h96, 3, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1, 8'hC3);
    xfer_int(8'hC3, 8'h3D, 3, 0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 8'h00);

    // random internal transfers
    for (int k = 0; k < 10; k++) begin
      xfer_int(8'($urandom), 8'($urandom), int'($urandom_range(0, 4)),
               int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
               1'b1, 1'b0, 0, 8'h00);
    end

    // external clock mode
    xfer_ext(8'hB2, 8'h4D, 1'b0, 1'b0, 1'b1);
    xfer_ext(8'h37, 8'hE1, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      xfer_ext(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule